// File: doc/BRIEF.md
# Register Rename Unit with Move Elimination

This block renames the register names of an out-of-order core. A small set of architectural register names is mapped onto a larger pool of physical registers. Each cycle it can accept one decoded instruction with up to two source names and one destination name. For an ALU-style instruction it returns the physical tags of the sources and a freshly allocated destination tag. It also returns the tag that the destination name held before, which the retire logic later hands back through the commit port.

Register-to-register copies allocate nothing. The destination name is pointed at the source's physical register. Clearing idioms point the destination at a shared zero register that is always valid and is never released.

Every physical register has a reference count. One reference is held for each map entry that points at the register, and one for each in-flight instruction that reads it. The commit port drops the reference of an overwritten mapping. The completion port drops the source references of a finished instruction. A register goes back to the free pool when its count reaches zero. A writeback port marks results as valid. The ready flag returned with each renamed instruction sees a writeback made in the same cycle.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, architectural name i maps to physical register i, which holds valid data. The zero register is physical index PHYS_N-1 and is valid. Every other physical register is free. out_valid is low.
- R2: Sources are looked up in the map as it stood before this instruction's destination update. Two back-to-back instructions `rX = rX + rX` therefore read successive physical tags.
- R3: An ALU instruction (ren_kind 0, and the unused code 3) with ren_dst_use set takes the lowest-numbered free physical register. That register starts in the waiting state. out_old_tag reports the destination's previous mapping.
- R4: out_ready is 1 only if every source the instruction uses is valid. A writeback of that tag in the same cycle counts as valid. Move and clear instructions always report ready.
- R5: A move (ren_kind 1) sets the destination's mapping to the physical tag of source A. It allocates no register, and out_dst_tag equals out_src_a_tag.
- R6: A clear (ren_kind 2) maps its destination to the zero register, never stalls and allocates nothing.
- R7: A register that several names alias through moves is not freed until each of those mappings has been committed away. After that it is handed out again.
- R8: The source references held by an in-flight instruction keep its source register allocated. Each release on the completion port removes one of them.
- R9: When an allocation is needed and no register is free, stall is raised in the same cycle. The map, the pool and the counts stay unchanged, and out_valid is low in the following cycle.
- R10: The zero register is never allocated. Commits and releases that name it are ignored.
- R11: Each accepted instruction shows its results on the out_* ports, with out_valid high, in the cycle after the clock edge that accepted it. No results appear otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | An instruction is presented for renaming |
| ren_kind | input | 2 | 0 ALU, 1 move, 2 clear, 3 treated as ALU |
| ren_src_a | input | AW | Architectural name of source A |
| ren_src_a_use | input | 1 | Source A is read |
| ren_src_b | input | AW | Architectural name of source B |
| ren_src_b_use | input | 1 | Source B is read |
| ren_dst | input | AW | Architectural destination name |
| ren_dst_use | input | 1 | An ALU instruction writes a destination |
| wb_valid | input | 1 | Writeback strobe |
| wb_tag | input | TW | Physical register whose result is now valid |
| cm_valid | input | 1 | Commit strobe for an overwritten mapping |
| cm_tag | input | TW | Physical tag whose map reference is dropped |
| done_valid | input | 1 | An instruction has finished reading its sources |
| done_a_use | input | 1 | Drop the reference for done_a_tag |
| done_a_tag | input | TW | First source tag of the finished instruction |
| done_b_use | input | 1 | Drop the reference for done_b_tag |
| done_b_tag | input | TW | Second source tag of the finished instruction |
| stall | output | 1 | Combinational: the presented instruction is not accepted |
| out_valid | output | 1 | Registered results below are valid |
| out_src_a_tag | output | TW | Physical tag of source A |
| out_src_b_tag | output | TW | Physical tag of source B |
| out_dst_tag | output | TW | Physical tag of the destination |
| out_old_tag | output | TW | Previous mapping of the destination |
| out_ready | output | 1 | All used sources are valid |

## Verification
The properties assume that the surrounding core keeps the reference bookkeeping honest. Commit and completion strobes only name references that are really held. A writeback only targets a register that is waiting for its result. The stimulus keeps to this. It commits only tags that an earlier rename reported as overwritten, and it releases only source tags of instructions already renamed. A reference model in the bench applies the same rules, so the tags it expects depend on that lawful use. The stall case is reached by allocating until the model's pool is empty. Nothing is committed during that run.

// File: rtl/rn_pkg.sv
package rn_pkg;

  // Instruction class presented at rename
  typedef enum logic [1:0] {
    K_ALU   = 2'd0,
    K_MOVE  = 2'd1,
    K_CLEAR = 2'd2,
    K_RSVD  = 2'd3
  } ren_kind_e;

  // Life cycle of one physical register
  typedef enum logic [1:0] {
    PS_FREE  = 2'd0,
    PS_WAIT  = 2'd1,
    PS_VALID = 2'd2
  } preg_state_e;

endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter  int ARCH_N = 16,
  parameter  int PHYS_N = 64,
  localparam int AW     = $clog2(ARCH_N),
  localparam int TW     = $clog2(PHYS_N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_a_idx,
  input  logic [AW-1:0] rd_b_idx,
  input  logic [AW-1:0] rd_d_idx,
  output logic [TW-1:0] rd_a_tag,
  output logic [TW-1:0] rd_b_tag,
  output logic [TW-1:0] rd_d_tag,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [TW-1:0] wr_tag
);

  logic [TW-1:0] map_q [ARCH_N];

  // One write port, three asynchronous read ports; reads see the pre-update map
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ARCH_N; i++) map_q[i] <= TW'(i);
    end else if (wr_en) begin
      map_q[wr_idx] <= wr_tag;
    end
  end

  assign rd_a_tag = map_q[rd_a_idx];
  assign rd_b_tag = map_q[rd_b_idx];
  assign rd_d_tag = map_q[rd_d_idx];

endmodule

// File: rtl/rn_free_pick.sv
module rn_free_pick #(
  parameter  int PHYS_N = 64,
  localparam int TW     = $clog2(PHYS_N)
) (
  input  logic [PHYS_N-1:0] free_vec,
  output logic              found,
  output logic [TW-1:0]     idx
);

  // Lowest index wins: scan from the top so the last hit is the smallest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = PHYS_N - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        found = 1'b1;
        idx   = TW'(i);
      end
    end
  end

endmodule

// File: rtl/rn_preg_status.sv
module rn_preg_status
  import rn_pkg::*;
#(
  parameter  int ARCH_N = 16,
  parameter  int PHYS_N = 64,
  parameter  int CNT_W  = 8,
  localparam int TW     = $clog2(PHYS_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic [TW-1:0]     alloc_tag,
  input  logic              ref_a_en,
  input  logic [TW-1:0]     ref_a_tag,
  input  logic              ref_b_en,
  input  logic [TW-1:0]     ref_b_tag,
  input  logic              ref_m_en,
  input  logic [TW-1:0]     ref_m_tag,
  input  logic              drop_c_en,
  input  logic [TW-1:0]     drop_c_tag,
  input  logic              drop_a_en,
  input  logic [TW-1:0]     drop_a_tag,
  input  logic              drop_b_en,
  input  logic [TW-1:0]     drop_b_tag,
  input  logic              wb_en,
  input  logic [TW-1:0]     wb_tag,
  output logic [PHYS_N-1:0] free_vec,
  output logic [PHYS_N-1:0] valid_vec
);

  for (genvar g = 0; g < PHYS_N; g++) begin : g_preg
    localparam logic [TW-1:0] ME = TW'(g);

    if (g == PHYS_N - 1) begin : g_zero
      // Shared zero register: permanently valid, never counted, never free
      assign free_vec[g]  = 1'b0;
      assign valid_vec[g] = 1'b1;
    end else begin : g_norm
      preg_state_e      st_q;
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] up;
      logic [CNT_W-1:0] dn;
      logic [CNT_W-1:0] cnt_nx;

      always_comb begin
        up = CNT_W'(ref_a_en && (ref_a_tag == ME))
           + CNT_W'(ref_b_en && (ref_b_tag == ME))
           + CNT_W'(ref_m_en && (ref_m_tag == ME));
        dn = CNT_W'(drop_c_en && (drop_c_tag == ME))
           + CNT_W'(drop_a_en && (drop_a_tag == ME))
           + CNT_W'(drop_b_en && (drop_b_tag == ME));
        cnt_nx = cnt_q + up - dn;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          st_q  <= (g < ARCH_N) ? PS_VALID : PS_FREE;
          cnt_q <= (g < ARCH_N) ? CNT_W'(1) : '0;
        end else if (alloc_en && (alloc_tag == ME)) begin
          st_q  <= PS_WAIT;
          cnt_q <= CNT_W'(1);
        end else if (st_q != PS_FREE) begin
          cnt_q <= cnt_nx;
          if (cnt_nx == '0) begin
            st_q <= PS_FREE;
          end else if (wb_en && (wb_tag == ME) && (st_q == PS_WAIT)) begin
            st_q <= PS_VALID;
          end
        end
      end

      assign free_vec[g]  = (st_q == PS_FREE);
      assign valid_vec[g] = (st_q == PS_VALID);
    end
  end

endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit
  import rn_pkg::*;
#(
  parameter  int ARCH_N = 16,
  parameter  int PHYS_N = 64,
  parameter  int CNT_W  = 8,
  localparam int AW     = $clog2(ARCH_N),
  localparam int TW     = $clog2(PHYS_N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ren_valid,
  input  logic [1:0]    ren_kind,
  input  logic [AW-1:0] ren_src_a,
  input  logic          ren_src_a_use,
  input  logic [AW-1:0] ren_src_b,
  input  logic          ren_src_b_use,
  input  logic [AW-1:0] ren_dst,
  input  logic          ren_dst_use,
  input  logic          wb_valid,
  input  logic [TW-1:0] wb_tag,
  input  logic          cm_valid,
  input  logic [TW-1:0] cm_tag,
  input  logic          done_valid,
  input  logic          done_a_use,
  input  logic [TW-1:0] done_a_tag,
  input  logic          done_b_use,
  input  logic [TW-1:0] done_b_tag,
  output logic          stall,
  output logic          out_valid,
  output logic [TW-1:0] out_src_a_tag,
  output logic [TW-1:0] out_src_b_tag,
  output logic [TW-1:0] out_dst_tag,
  output logic [TW-1:0] out_old_tag,
  output logic          out_ready
);

  localparam logic [TW-1:0] ZERO_TAG = TW'(PHYS_N - 1);

  ren_kind_e         kind;
  logic              is_alu, is_mv, is_clr;
  logic              need_alloc, fire, map_wr;
  logic [TW-1:0]     tag_a, tag_b, tag_old, new_tag;
  logic              pick_found;
  logic [TW-1:0]     pick_idx;
  logic [PHYS_N-1:0] free_vec, valid_vec;
  logic              a_rdy, b_rdy, all_rdy;

  assign kind   = ren_kind_e'(ren_kind);
  assign is_mv  = (kind == K_MOVE);
  assign is_clr = (kind == K_CLEAR);
  assign is_alu = !is_mv && !is_clr;

  assign need_alloc = ren_valid && is_alu && ren_dst_use;
  assign stall      = need_alloc && !pick_found;
  assign fire       = ren_valid && !stall;
  assign map_wr     = fire && (is_mv || is_clr || ren_dst_use);

  always_comb begin
    if (is_mv)       new_tag = tag_a;
    else if (is_clr) new_tag = ZERO_TAG;
    else             new_tag = pick_idx;
  end

  rn_map_table #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N)) map_i (
    .clk      (clk),
    .rst      (rst),
    .rd_a_idx (ren_src_a),
    .rd_b_idx (ren_src_b),
    .rd_d_idx (ren_dst),
    .rd_a_tag (tag_a),
    .rd_b_tag (tag_b),
    .rd_d_tag (tag_old),
    .wr_en    (map_wr),
    .wr_idx   (ren_dst),
    .wr_tag   (new_tag)
  );

  rn_free_pick #(.PHYS_N(PHYS_N)) pick_i (
    .free_vec (free_vec),
    .found    (pick_found),
    .idx      (pick_idx)
  );

  rn_preg_status #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N), .CNT_W(CNT_W)) stat_i (
    .clk        (clk),
    .rst        (rst),
    .alloc_en   (need_alloc && pick_found),
    .alloc_tag  (pick_idx),
    .ref_a_en   (fire && is_alu && ren_src_a_use),
    .ref_a_tag  (tag_a),
    .ref_b_en   (fire && is_alu && ren_src_b_use),
    .ref_b_tag  (tag_b),
    .ref_m_en   (fire && is_mv),
    .ref_m_tag  (tag_a),
    .drop_c_en  (cm_valid),
    .drop_c_tag (cm_tag),
    .drop_a_en  (done_valid && done_a_use),
    .drop_a_tag (done_a_tag),
    .drop_b_en  (done_valid && done_b_use),
    .drop_b_tag (done_b_tag),
    .wb_en      (wb_valid),
    .wb_tag     (wb_tag),
    .free_vec   (free_vec),
    .valid_vec  (valid_vec)
  );

  // Readiness sees a writeback landing in this same cycle
  assign a_rdy   = valid_vec[tag_a] || (wb_valid && (wb_tag == tag_a));
  assign b_rdy   = valid_vec[tag_b] || (wb_valid && (wb_tag == tag_b));
  assign all_rdy = !is_alu ||
                   ((!ren_src_a_use || a_rdy) && (!ren_src_b_use || b_rdy));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_src_a_tag <= '0;
      out_src_b_tag <= '0;
      out_dst_tag   <= '0;
      out_old_tag   <= '0;
      out_ready     <= 1'b0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_src_a_tag <= tag_a;
        out_src_b_tag <= tag_b;
        out_dst_tag   <= new_tag;
        out_old_tag   <= tag_old;
        out_ready     <= all_rdy;
      end
    end
  end

endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
  parameter  int PHYS_N = 64,
  localparam int TW     = $clog2(PHYS_N)
) (
  input logic          clk,
  input logic          rst,
  input logic          ren_valid,
  input logic [1:0]    ren_kind,
  input logic          ren_src_a_use,
  input logic          ren_dst_use,
  input logic          stall,
  input logic          out_valid,
  input logic [TW-1:0] out_src_a_tag,
  input logic [TW-1:0] out_dst_tag,
  input logic          out_ready
);

  localparam logic [TW-1:0] ZERO_TAG = TW'(PHYS_N - 1);

  // R9
  stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> !out_valid);

  // R11
  accept_out_chk: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && !stall) |=> out_valid);

  // R5
  move_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && !stall && ren_kind == 2'd1) |=>
      (out_dst_tag == out_src_a_tag) && out_ready);

  // R6
  clear_nostall_chk: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && ren_kind == 2'd2) |-> !stall);

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && ren_kind == 2'd2) |=> (out_dst_tag == ZERO_TAG) && out_ready);

  // R3
  alloc_fresh_chk: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && !stall && ren_kind == 2'd0 && ren_dst_use && ren_src_a_use) |=>
      (out_dst_tag != out_src_a_tag) && (out_dst_tag != ZERO_TAG));

endmodule

bind rn_rename_unit rn_rename_chk #(.PHYS_N(PHYS_N)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .ren_valid     (ren_valid),
  .ren_kind      (ren_kind),
  .ren_src_a_use (ren_src_a_use),
  .ren_dst_use   (ren_dst_use),
  .stall         (stall),
  .out_valid     (out_valid),
  .out_src_a_tag (out_src_a_tag),
  .out_dst_tag   (out_dst_tag),
  .out_ready     (out_ready)
);

// File: tb/rn_rename_unit_tb_top.sv
module rn_rename_unit_tb_top;

  localparam int NA = 16;
  localparam int NP = 64;
  localparam int ZT = NP - 1;

  logic       clk = 1'b0;
  logic       rst;
  logic       ren_valid, ren_src_a_use, ren_src_b_use, ren_dst_use;
  logic [1:0] ren_kind;
  logic [3:0] ren_src_a, ren_src_b, ren_dst;
  logic       wb_valid, cm_valid, done_valid, done_a_use, done_b_use;
  logic [5:0] wb_tag, cm_tag, done_a_tag, done_b_tag;
  logic       stall, out_valid, out_ready;
  logic [5:0] out_src_a_tag, out_src_b_tag, out_dst_tag, out_old_tag;

  always #4 clk = ~clk;

  rn_rename_unit dut_i (
    .clk(clk), .rst(rst), .ren_valid(ren_valid), .ren_kind(ren_kind),
    .ren_src_a(ren_src_a), .ren_src_a_use(ren_src_a_use),
    .ren_src_b(ren_src_b), .ren_src_b_use(ren_src_b_use),
    .ren_dst(ren_dst), .ren_dst_use(ren_dst_use),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .cm_valid(cm_valid), .cm_tag(cm_tag),
    .done_valid(done_valid), .done_a_use(done_a_use), .done_a_tag(done_a_tag),
    .done_b_use(done_b_use), .done_b_tag(done_b_tag), .stall(stall),
    .out_valid(out_valid), .out_src_a_tag(out_src_a_tag),
    .out_src_b_tag(out_src_b_tag), .out_dst_tag(out_dst_tag),
    .out_old_tag(out_old_tag), .out_ready(out_ready)
  );

  typedef struct {
    int    a; int b; int d; int o;
    bit    r; bit ua; bit ub; bit hd;
    string req;
  } exp_t;

  exp_t q[$];
  int   errors = 0;
  int   checks = 0;

  // Reference model: map, register state (0 free, 1 waiting, 2 valid), counts
  int m_map [NA];
  int m_st  [NP];
  int m_cnt [NP];

  // Side-port values applied in the next step
  bit s_wv, s_cv, s_dv, s_dau, s_dbu;
  int s_wt, s_ct, s_dat, s_dbt;
  bit chk_quiet = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit m_rdy(int t);
    return (m_st[t] == 2) || (s_wv && s_wt == t);
  endfunction

  task automatic m_drop(int t);
    if (t != ZT && m_st[t] != 0) begin
      m_cnt[t]--;
      if (m_cnt[t] == 0) m_st[t] = 0;
    end
  endtask

  function automatic int m_free_count();
    int n = 0;
    for (int i = 0; i < NP; i++) if (m_st[i] == 0) n++;
    return n;
  endfunction

  // Driver: one cycle of stimulus, expected results pushed to the scoreboard
  task automatic step(bit rv, int kind, int sa, bit ua, int sb, bit ub,
                      int d, bit ud, string req);
    int  ta, tb, to, pick, dst;
    bit  need, est, rdy;
    exp_t it;
    @(negedge clk);
    if (chk_quiet) begin
      chk(out_valid == 1'b0, "R9", "out_valid after stall", int'(out_valid), 0);
      chk_quiet = 0;
    end
    ren_valid = rv; ren_kind = 2'(kind);
    ren_src_a = 4'(sa); ren_src_a_use = ua;
    ren_src_b = 4'(sb); ren_src_b_use = ub;
    ren_dst = 4'(d); ren_dst_use = ud;
    wb_valid = s_wv; wb_tag = 6'(s_wt);
    cm_valid = s_cv; cm_tag = 6'(s_ct);
    done_valid = s_dv; done_a_use = s_dau; done_a_tag = 6'(s_dat);
    done_b_use = s_dbu; done_b_tag = 6'(s_dbt);
    #1;
    ta = m_map[sa]; tb = m_map[sb]; to = m_map[d];
    need = rv && (kind == 0 || kind == 3) && ud;
    pick = -1;
    for (int i = 0; i < NP; i++) if (m_st[i] == 0 && pick < 0) pick = i;
    est = need && (pick < 0);
    chk(stall == est, req, "stall", int'(stall), int'(est));
    if (rv && !est) begin
      if (kind == 1)      dst = ta;
      else if (kind == 2) dst = ZT;
      else                dst = pick;
      if (kind == 1 || kind == 2) rdy = 1;
      else rdy = (!ua || m_rdy(ta)) && (!ub || m_rdy(tb));
      it.a = ta; it.b = tb; it.d = dst; it.o = to; it.r = rdy;
      it.ua = ua && !(kind == 2); it.ub = ub && (kind == 0 || kind == 3);
      it.hd = (kind == 1 || kind == 2 || ud); it.req = req;
      q.push_back(it);
      if (need) begin m_st[pick] = 1; m_cnt[pick] = 1; end
      if (kind == 0 || kind == 3) begin
        if (ua && ta != ZT) m_cnt[ta]++;
        if (ub && tb != ZT) m_cnt[tb]++;
      end
      if (kind == 1 && ta != ZT) m_cnt[ta]++;
      if (it.hd) m_map[d] = dst;
    end
    if (s_wv && m_st[s_wt] == 1) m_st[s_wt] = 2;
    if (s_cv) m_drop(s_ct);
    if (s_dv && s_dau) m_drop(s_dat);
    if (s_dv && s_dbu) m_drop(s_dbt);
    s_wv = 0; s_cv = 0; s_dv = 0; s_dau = 0; s_dbu = 0;
  endtask

  task automatic idle(string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  // Monitor: compares registered results one cycle after acceptance
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (q.size() == 0) begin
          chk(0, "R11", "unexpected out_valid", 1, 0);
        end else begin
          e = q.pop_front();
          if (e.ua) chk(out_src_a_tag == 6'(e.a), e.req, "src_a tag", int'(out_src_a_tag), e.a);
          if (e.ub) chk(out_src_b_tag == 6'(e.b), e.req, "src_b tag", int'(out_src_b_tag), e.b);
          if (e.hd) begin
            chk(out_dst_tag == 6'(e.d), e.req, "dst tag", int'(out_dst_tag), e.d);
            chk(out_old_tag == 6'(e.o), e.req, "old tag", int'(out_old_tag), e.o);
          end
          chk(out_ready == e.r, e.req, "ready", int'(out_ready), int'(e.r));
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    chk(0, "R11", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t1, t2, alias_t, last_old;
    for (int i = 0; i < NP; i++) begin m_st[i] = 0; m_cnt[i] = 0; end
    for (int i = 0; i < NA; i++) begin m_map[i] = i; m_st[i] = 2; m_cnt[i] = 1; end
    m_st[ZT] = 2;
    rst = 1;
    ren_valid = 0; ren_kind = 0; ren_src_a = 0; ren_src_a_use = 0;
    ren_src_b = 0; ren_src_b_use = 0; ren_dst = 0; ren_dst_use = 0;
    wb_valid = 0; wb_tag = 0; cm_valid = 0; cm_tag = 0;
    done_valid = 0; done_a_use = 0; done_a_tag = 0; done_b_use = 0; done_b_tag = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(stall == 1'b0, "R1", "stall after reset", int'(stall), 0);
    idle("R1");
    // R1 R3: reset map and first allocation
    step(1, 0, 2, 1, 3, 1, 1, 1, "R1 R3");
    step(1, 0, 15, 1, 14, 1, 0, 1, "R1");
    // R2: self-dependent chain
    step(1, 0, 4, 1, 4, 1, 4, 1, "R2");
    t1 = m_map[4];
    step(1, 0, 4, 1, 4, 1, 4, 1, "R2 R4");
    t2 = m_map[4];
    // R4: same-cycle writeback bypass
    s_wv = 1; s_wt = t2;
    step(1, 0, 4, 1, 0, 1, 5, 1, "R4");
    // R5: move aliasing, no allocation consumed
    step(1, 1, 1, 1, 0, 0, 6, 1, "R5");
    step(1, 0, 7, 1, 7, 1, 7, 1, "R5 R3");
    // kind 3 behaves as ALU
    step(1, 3, 5, 1, 0, 0, 3, 1, "R3");
    // R6: clear and read of the zero register
    step(1, 2, 0, 0, 0, 0, 8, 1, "R6");
    step(1, 0, 8, 1, 8, 1, 9, 1, "R6 R4");
    // R10: commits and releases naming the zero register are ignored
    s_cv = 1; s_ct = ZT; idle("R10");
    s_dv = 1; s_dau = 1; s_dat = ZT; idle("R10");
    step(1, 0, 8, 1, 0, 0, 10, 1, "R10");
    // R7: aliased register freed only after both mappings commit away
    alias_t = m_map[1];
    step(1, 2, 0, 0, 0, 0, 1, 1, "R7");
    s_cv = 1; s_ct = alias_t; idle("R7");
    step(1, 0, 0, 0, 0, 0, 11, 1, "R7");
    step(1, 2, 0, 0, 0, 0, 6, 1, "R7");
    s_cv = 1; s_ct = alias_t; idle("R7");
    step(1, 0, 0, 0, 0, 0, 12, 1, "R7");
    // R8: source references hold a register until released
    s_cv = 1; s_ct = t1; idle("R8");
    step(1, 0, 0, 0, 0, 0, 13, 1, "R8");
    s_dv = 1; s_dau = 1; s_dat = t1; s_dbu = 1; s_dbt = t1; idle("R8");
    step(1, 0, 0, 0, 0, 0, 13, 1, "R8");
    // R9: exhaust the pool, then stall
    last_old = m_map[15];
    while (m_free_count() > 0) begin
      last_old = m_map[15];
      step(1, 0, 0, 0, 0, 0, 15, 1, "R9");
    end
    step(1, 0, 0, 0, 0, 0, 15, 1, "R9");
    chk_quiet = 1;
    idle("R9");
    step(1, 1, 15, 1, 0, 0, 12, 1, "R9");
    s_cv = 1; s_ct = last_old; idle("R7");
    step(1, 0, 0, 0, 0, 0, 14, 1, "R7 R9");
    idle("R11");
    idle("R11");
    chk(q.size() == 0, "R11", "scoreboard leftovers", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule